// File: doc/BRIEF.md
# Conversion Cycle Timing Controller

This block paces the measurement datapath of a metering front end. It turns the master clock into an internal clock enable by dividing it by a small programmable factor. It groups internal ticks into sample periods of a fixed length, and groups sample periods into conversion cycles whose length is a programmable count N. From these it issues a strobe per sample period and a strobe per conversion cycle. The cycle strobe marks where the energy and RMS results are computed. A data-ready strobe follows one clock after each cycle strobe.

Counting begins on a start command. The cycle count is captured at start and again at every cycle boundary, so software may rewrite it at any time. When the captured N is below a minimum, the cycle still ends on time, but the calculation strobe stays low. A self-clearing soft reset bit holds a reset request high for a short fixed number of master clocks. During that request the block stops counting, and it then waits for a new start.

Top module: `conv_cycle_timer`

## Requirements
- R1: `tick_en` is high once every K master clocks. K is 2 when `div_sel` is 4'd2, 4 when it is 4'd4, and 1 for every other code, so `tick_en` is high on every clock for those codes. `tick_en` is low while `rst_req` is high.
- R2: Before the first start command, and after reset, `sample_stb` never pulses. While running, it pulses together with `tick_en` on every SAMPLE_TICKS-th tick counted from start.
- R3: `cycle_stb` pulses only together with `sample_stb`, on every N-th sample strobe of a cycle.
- R4: N is the value of `cyc_len` captured on the start edge and on each cycle-boundary edge. A change between those edges has no effect until the next boundary. A captured value of 0 behaves as 1.
- R5: `calc_stb` equals `cycle_stb` when the captured N is at least N_MIN (default 11), and is low otherwise.
- R6: `ready_stb` is high exactly in the clock after each `cycle_stb`.
- R7: A clock with `rst_bit_wr` high while `rst_req` is low makes `rst_req` high for exactly RST_CYCLES clocks, which must be fewer than 10. The bit then clears itself. That edge and the following clocks stop counting and clear `ready_stb`.
- R8: While `rst_req` is high, `rst_bit_wr` and `start` are ignored. After `rst_req` falls, no strobe appears until a new start.
- R9: After the synchronous reset `rst`, all strobes and `rst_req` are low.
- R10: A start command while the block is already running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 4 | Clock divider code |
| cyc_len | input | 24 | Cycle count N, in sample periods |
| rst_bit_wr | input | 1 | Write of 1 to the soft reset bit |
| start | input | 1 | Start conversion command |
| tick_en | output | 1 | Internal clock enable |
| sample_stb | output | 1 | End of a sample period |
| cycle_stb | output | 1 | End of a conversion cycle |
| calc_stb | output | 1 | RMS and energy calculation enable |
| ready_stb | output | 1 | Data ready, one clock after the cycle end |
| rst_req | output | 1 | Soft reset request, high for the reset cycle |

## Verification
The bench builds the block with SAMPLE_TICKS = 8 and RST_CYCLES = 6, and keeps N_MIN at 11. The short sample period lets a full cycle with N above the minimum finish within a few hundred clocks, even at divide-by-4. Dozens of cycle boundaries can therefore be seen, including rewrites of N in the middle of a cycle, the N = 0 case and the step across the minimum-N threshold. The shorter reset length also checks that the request length follows the parameter rather than a fixed constant.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    parameter int CNT_W = 24;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        DIV1 = 3'd1,
        DIV2 = 3'd2,
        DIV4 = 3'd4
    } div_e;

    typedef struct packed {
        logic sample;
        logic cycle;
        logic calc;
        logic ready;
    } strobe_t;

    // Legal codes pass through; anything else runs undivided.
    function automatic div_e div_decode(input logic [3:0] code);
        case (code)
            4'd2:    return DIV2;
            4'd4:    return DIV4;
            default: return DIV1;
        endcase
    endfunction

    // A zero cycle count would never end a cycle; treat it as one.
    function automatic cnt_t len_fix(input cnt_t n);
        return (n == '0) ? cnt_t'(1) : n;
    endfunction

endpackage

// File: rtl/ctm_clkdiv.sv
module ctm_clkdiv
    import ctm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic [3:0] div_sel,
    output logic       tick
);
    localparam int DW = 2;

    logic [DW-1:0] div_cnt;
    div_e          k_sel;
    logic          at_end;

    assign k_sel  = div_decode(div_sel);
    // ">=" lets a shrinking divider wrap at once instead of running long.
    assign at_end = ({1'b0, div_cnt} >= (3'(k_sel) - 3'd1));
    assign tick   = at_end;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            div_cnt <= '0;
        end else if (at_end) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctm_cycle_seq.sv
module ctm_cycle_seq
    import ctm_pkg::*;
#(
    parameter int SAMPLE_TICKS = 1024,
    parameter int N_DEFAULT    = 4000,
    parameter int N_MIN        = 11
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    start,
    input  logic    tick,
    input  cnt_t    cyc_len,
    output strobe_t stb
);
    localparam int SMP_W = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_TICKS - 1);

    logic             running;
    logic [SMP_W-1:0] smp_cnt;
    cnt_t             cyc_cnt;
    cnt_t             n_act;
    logic             rdy_q;
    logic             smp_last;
    logic             samp_w;
    logic             cyc_w;

    assign smp_last = (smp_cnt == SMP_LAST);
    assign samp_w   = running && tick && smp_last;
    assign cyc_w    = samp_w && (cyc_cnt == (n_act - cnt_t'(1)));

    assign stb.sample = samp_w;
    assign stb.cycle  = cyc_w;
    assign stb.calc   = cyc_w && (n_act >= cnt_t'(N_MIN));
    assign stb.ready  = rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            smp_cnt <= '0;
            cyc_cnt <= '0;
            n_act   <= len_fix(cnt_t'(N_DEFAULT));
            rdy_q   <= 1'b0;
        end else if (clr) begin
            running <= 1'b0;
            smp_cnt <= '0;
            cyc_cnt <= '0;
            rdy_q   <= 1'b0;
        end else begin
            rdy_q <= cyc_w;
            if (!running) begin
                if (start) begin
                    running <= 1'b1;
                    smp_cnt <= '0;
                    cyc_cnt <= '0;
                    n_act   <= len_fix(cyc_len);
                end
            end else if (tick) begin
                if (smp_last) begin
                    smp_cnt <= '0;
                    if (cyc_w) begin
                        cyc_cnt <= '0;
                        n_act   <= len_fix(cyc_len);
                    end else begin
                        cyc_cnt <= cyc_cnt + cnt_t'(1);
                    end
                end else begin
                    smp_cnt <= smp_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ctm_softrst.sv
module ctm_softrst #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    output logic busy,
    output logic clr
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYCLES - 1);

    logic [RC_W-1:0] cnt;

    // The write edge itself already clears the datapath.
    assign clr = busy || wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == RC_LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (wr) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end
endmodule

// File: rtl/conv_cycle_timer.sv
module conv_cycle_timer
    import ctm_pkg::*;
#(
    parameter int SAMPLE_TICKS = 1024,
    parameter int N_DEFAULT    = 4000,
    parameter int N_MIN        = 11,
    parameter int RST_CYCLES   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       div_sel,
    input  logic [CNT_W-1:0] cyc_len,
    input  logic             rst_bit_wr,
    input  logic             start,
    output logic             tick_en,
    output logic             sample_stb,
    output logic             cycle_stb,
    output logic             calc_stb,
    output logic             ready_stb,
    output logic             rst_req
);
    logic    sr_busy;
    logic    sr_clr;
    logic    tick_raw;
    strobe_t stb;

    ctm_softrst #(.RST_CYCLES(RST_CYCLES)) u_sr (
        .clk  (clk),
        .rst  (rst),
        .wr   (rst_bit_wr),
        .busy (sr_busy),
        .clr  (sr_clr)
    );

    ctm_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .hold    (sr_clr),
        .div_sel (div_sel),
        .tick    (tick_raw)
    );

    ctm_cycle_seq #(
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .N_DEFAULT    (N_DEFAULT),
        .N_MIN        (N_MIN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (sr_clr),
        .start   (start),
        .tick    (tick_raw),
        .cyc_len (cnt_t'(cyc_len)),
        .stb     (stb)
    );

    assign tick_en    = tick_raw && !sr_busy;
    assign sample_stb = stb.sample;
    assign cycle_stb  = stb.cycle;
    assign calc_stb   = stb.calc;
    assign ready_stb  = stb.ready;
    assign rst_req    = sr_busy;
endmodule

// File: rtl/conv_cycle_timer_chk.sv
module conv_cycle_timer_chk #(
    parameter int RC = 8
) (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic sample_stb,
    input logic cycle_stb,
    input logic calc_stb,
    input logic ready_stb,
    input logic rst_req
);
    logic [4:0] req_len;

    always_ff @(posedge clk) begin
        if (rst || !rst_req) req_len <= '0;
        else                 req_len <= req_len + 1'b1;
    end

    initial a_r7_len_limit : assert (RC >= 1 && RC < 10);

    a_r2_sample_on_tick : assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> tick_en);

    a_r3_cycle_on_sample : assert property (@(posedge clk) disable iff (rst)
        cycle_stb |-> sample_stb);

    a_r5_calc_in_cycle : assert property (@(posedge clk) disable iff (rst)
        calc_stb |-> cycle_stb);

    a_r6_ready_after : assert property (@(posedge clk) disable iff (rst)
        cycle_stb |=> ready_stb);

    a_r6_ready_source : assert property (@(posedge clk) disable iff (rst)
        $rose(ready_stb) |-> $past(cycle_stb));

    a_r7_req_bounded : assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (req_len < 5'(RC)));

    a_r8_quiet_in_req : assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !(sample_stb || tick_en || ready_stb));
endmodule

bind conv_cycle_timer conv_cycle_timer_chk #(.RC(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .sample_stb (sample_stb),
    .cycle_stb  (cycle_stb),
    .calc_stb   (calc_stb),
    .ready_stb  (ready_stb),
    .rst_req    (rst_req)
);

// File: tb/conv_cycle_timer_tb_top.sv
module conv_cycle_timer_tb_top;
    localparam int S   = 8;
    localparam int RC  = 6;
    localparam int NMN = 11;
    localparam int WD  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  div_sel = 4'd1;
    logic [23:0] cyc_len = 24'd3;
    logic        rst_bit_wr = 1'b0;
    logic        start = 1'b0;
    logic tick_en, sample_stb, cycle_stb, calc_stb, ready_stb, rst_req;

    int compared = 0;
    int mismatched = 0;
    int clocks = 0;
    bit done = 0;
    string phase = "R9";

    always #10 clk = ~clk;

    conv_cycle_timer #(
        .SAMPLE_TICKS (S),
        .N_MIN        (NMN),
        .RST_CYCLES   (RC)
    ) dut_i (
        .clk (clk), .rst (rst), .div_sel (div_sel), .cyc_len (cyc_len),
        .rst_bit_wr (rst_bit_wr), .start (start), .tick_en (tick_en),
        .sample_stb (sample_stb), .cycle_stb (cycle_stb), .calc_stb (calc_stb),
        .ready_stb (ready_stb), .rst_req (rst_req)
    );

    // Behavioural model: ticks are counted within a whole cycle.
    bit     m_run = 0, m_sr = 0, m_rdy = 0;
    int     m_div = 0, m_src = 0;
    longint m_tin = 0, m_n = 4000;
    bit     e_tick, e_samp, e_cyc, e_calc;

    function automatic int kval(input logic [3:0] c);
        if (c == 4'd2) return 2;
        if (c == 4'd4) return 4;
        return 1;
    endfunction

    function automatic longint nfix(input logic [23:0] v);
        return (v == 0) ? 1 : longint'(v);
    endfunction

    task automatic eval_exp();
        int k = kval(div_sel);
        e_tick = !m_sr && (m_div >= k - 1);
        e_samp = m_run && e_tick && (((m_tin + 1) % S) == 0);
        e_cyc  = e_samp && ((m_tin + 1) == longint'(S) * m_n);
        e_calc = e_cyc && (m_n >= NMN);
    endtask

    always @(posedge clk) begin
        int k;
        k = kval(div_sel);
        eval_exp();
        if (rst) begin
            m_run = 0; m_sr = 0; m_rdy = 0; m_div = 0; m_src = 0;
            m_tin = 0; m_n = 4000;
        end else if (m_sr) begin
            m_run = 0; m_rdy = 0; m_div = 0; m_tin = 0;
            if (m_src == RC - 1) begin m_sr = 0; m_src = 0; end
            else m_src++;
        end else if (rst_bit_wr) begin
            m_sr = 1; m_src = 0; m_run = 0; m_rdy = 0; m_div = 0; m_tin = 0;
        end else begin
            m_rdy = e_cyc;
            m_div = (m_div >= k - 1) ? 0 : m_div + 1;
            if (!m_run) begin
                if (start) begin m_run = 1; m_tin = 0; m_n = nfix(cyc_len); end
            end else if (e_tick) begin
                if (e_cyc) begin m_tin = 0; m_n = nfix(cyc_len); end
                else m_tin++;
            end
        end
    end

    task automatic cmp(input string req, input bit act, input bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s (phase %s) t=%0t actual=%0b expected=%0b",
                     req, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            eval_exp();
            cmp("R1 tick_en",    tick_en,    e_tick);
            cmp("R2 sample_stb", sample_stb, e_samp);
            cmp("R3 cycle_stb",  cycle_stb,  e_cyc);
            cmp("R5 calc_stb",   calc_stb,   e_calc);
            cmp("R6 ready_stb",  ready_stb,  m_rdy);
            cmp("R7 rst_req",    rst_req,    m_sr);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        clocks++;
        if (clocks > WD && !done) begin
            mismatched++;
            $display("FAIL watchdog expired: actual=%0d clocks expected<=%0d", clocks, WD);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic pulse_start();
        start = 1'b1; step(1); start = 1'b0;
    endtask

    task automatic pulse_wr();
        rst_bit_wr = 1'b1; step(1); rst_bit_wr = 1'b0;
    endtask

    int seen_cyc = 0;
    always @(negedge clk) if (cycle_stb) seen_cyc++;

    initial begin
        step(3);
        rst = 1'b0;
        // R9: idle after reset, nothing strobes before start (R2)
        phase = "R9"; step(30);
        compared++;
        if (seen_cyc != 0) begin
            mismatched++;
            $display("FAIL R9 idle cycles actual=%0d expected=0", seen_cyc);
        end
        // R2/R3/R5: K=1, N=3 (below minimum, calc gated)
        phase = "R5"; cyc_len = 24'd3; pulse_start(); step(120);
        // R4: mid-cycle change of N takes effect at boundary, calc opens at 12
        phase = "R4"; step(7); cyc_len = 24'd12; step(300);
        // R5 threshold: N=11 passes, N=10 gated
        phase = "R5"; cyc_len = 24'd11; step(200); cyc_len = 24'd10; step(200);
        // R10: start while running
        phase = "R10"; cyc_len = 24'd2; pulse_start(); step(5); pulse_start(); step(60);
        // R1: divider codes 2, 4 and illegal 7 and 0
        phase = "R1"; div_sel = 4'd2; step(100);
        div_sel = 4'd4; step(200);
        div_sel = 4'd7; step(60);
        div_sel = 4'd0; step(40);
        div_sel = 4'd4; step(50);
        // R4: N=0 behaves as 1
        phase = "R4"; cyc_len = 24'd0; step(150);
        // R7: soft reset request
        phase = "R7"; div_sel = 4'd1; cyc_len = 24'd2; pulse_wr(); step(2);
        // R8: write and start during the request are ignored
        phase = "R8"; pulse_wr(); pulse_start(); step(RC + 20);
        seen_cyc = 0; step(60);
        compared++;
        if (seen_cyc != 0) begin
            mismatched++;
            $display("FAIL R8 cycles after request actual=%0d expected=0", seen_cyc);
        end
        // restart after soft reset, then a write at a cycle boundary area
        phase = "R7"; pulse_start(); step(45); pulse_wr(); step(RC + 5);
        pulse_start(); step(80);
        // R9: synchronous reset mid-run
        phase = "R9"; rst = 1'b1; step(2); rst = 1'b0; step(40);
        finish_run();
    end
endmodule